// File: doc/BRIEF.md
# Multi-Converter Readout Sequencer

This block is the host-side controller for a group of 16-bit sampling converters that share one convert strobe, one serial clock and one serial data return line, each converter having its own active-low select. A single start request begins one conversion that all converters perform together. The sequencer holds the convert strobe high and keeps every select high for the full worst-case conversion time. It then reads the converters one after another by lowering each select in turn and clocking out sixteen bits.

Each captured word leaves the block on a valid/ready output together with the index of the channel it came from. A word that has not been accepted stalls the next channel's read until it is taken. After the last channel has been captured, the convert strobe falls. The sequencer then waits a configurable acquisition time before it accepts another start. The number of channels, the serial clock half-period, the conversion wait and the acquisition wait are all parameters.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `cnvOut` and `sckOut` are 0, every bit of `selN` is 1 and `outValid` is 0.
- R2: A `startReq` sampled high while the block is idle raises `cnvOut` on the next clock edge, with every select line high at that moment. `cnvOut` stays high whenever any select is low, and for every channel word except the last.
- R3: After `cnvOut` rises, all select lines stay high for at least `CONV_CYCLES` clock cycles.
- R4: At most one bit of `selN` is low at any time. Within one conversion the channels are selected once each, in the order 0, 1, ..., NUM_CH-1.
- R5: While a select is low, `sckOut` makes exactly 16 rising transitions, each phase lasting `SCK_HALF` clocks. `sckOut` is low on every cycle in which `selN` changes.
- R6: `dataIn` is sampled at the clock edge on which `sckOut` falls. The first sample is the word's most significant bit, so `outData` equals the 16 bits presented MSB first.
- R7: Between the release of one select and the lowering of the next, all selects stay high for at least `2*SCK_HALF` cycles.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outChan` hold their values, and no select goes low. A word is consumed on a cycle with `outValid` and `outReady` both 1.
- R9: `cnvOut` falls on the edge that loads the last channel's word. For `ACQ_CYCLES` cycles after that edge, and also during any conversion or readout, `startReq` is ignored.
- R10: `outChan` gives the index (0 based) of the channel whose word is in `outData`, and is always below `NUM_CH` while `outValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request for one shared conversion |
| cnvOut | output | 1 | Shared convert strobe |
| sckOut | output | 1 | Shared serial clock |
| selN | output | NUM_CH | Active-low per-converter select |
| dataIn | input | 1 | Shared serial data return |
| outValid | output | 1 | Result word available |
| outReady | input | 1 | Consumer accepts the result word |
| outData | output | 16 | Result word |
| outChan | output | CH_W | Channel index of the result word |

## Verification
Several properties are checked on every cycle. No two selects are ever low together, and the serial clock is low whenever a select moves. The convert strobe covers every active select, and the select lines stay high through the conversion window, which is measured by a counter. An unaccepted word stays frozen, and no read starts while a word is pending. Only the bench scenarios can show the rest: the captured words match the pattern the converter model shifts out MSB first, each select sees exactly sixteen clock pulses, the inter-channel gaps have the required length, and start requests during a busy or acquisition period produce no extra conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV,
    S_GAP,
    S_LOW,
    S_HIGH,
    S_ACQ
  } seq_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrShift;
    logic shiftEn;
    logic loadOut;
  } dp_ctrl_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SCK_HALF    = 2,
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 8,
  parameter int WORD_W      = 16,
  parameter int CH_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              outValid,
  output dp_ctrl_t          ctl,
  output logic [CH_W-1:0]   chanIdx,
  output logic              cnvOut,
  output logic              sckOut,
  output logic [NUM_CH-1:0] selN
);

  localparam int GAP_CYCLES = 2 * SCK_HALF;
  localparam int BIG_A      = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int TMR_MAX    = (BIG_A > GAP_CYCLES) ? BIG_A : GAP_CYCLES;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int BIT_W      = $clog2(WORD_W);

  localparam logic [TMR_W-1:0] T_CONV = TMR_W'(CONV_CYCLES - 1);
  localparam logic [TMR_W-1:0] T_ACQ  = TMR_W'(ACQ_CYCLES - 1);
  localparam logic [TMR_W-1:0] T_GAP  = TMR_W'(GAP_CYCLES - 1);
  localparam logic [TMR_W-1:0] T_HALF = TMR_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  seq_state_e        state, stateNext;
  logic [TMR_W-1:0]  tmr, tmrNext;
  logic [BIT_W-1:0]  bitCnt, bitNext;
  logic [CH_W-1:0]   chan, chanNext;
  logic              tmrDone;

  assign tmrDone = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tmr    <= '0;
      bitCnt <= '0;
      chan   <= '0;
    end else begin
      state  <= stateNext;
      tmr    <= tmrNext;
      bitCnt <= bitNext;
      chan   <= chanNext;
    end
  end

  always_comb begin
    stateNext = state;
    tmrNext   = tmrDone ? tmr : tmr - 1'b1;
    bitNext   = bitCnt;
    chanNext  = chan;
    ctl       = '0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          stateNext = S_CONV;
          tmrNext   = T_CONV;
          chanNext  = '0;
        end
      end
      S_CONV: begin
        if (tmrDone) begin
          stateNext = S_GAP;
          tmrNext   = T_GAP;
        end
      end
      S_GAP: begin
        // next read only once the output register is free
        if (tmrDone && !outValid) begin
          stateNext    = S_LOW;
          tmrNext      = T_HALF;
          bitNext      = '0;
          ctl.clrShift = 1'b1;
        end
      end
      S_LOW: begin
        if (tmrDone) begin
          stateNext = S_HIGH;
          tmrNext   = T_HALF;
        end
      end
      S_HIGH: begin
        if (tmrDone) begin
          // clock falls on this edge: take the bit now
          ctl.shiftEn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            ctl.loadOut = 1'b1;
            if (chan == LAST_CH) begin
              stateNext = S_ACQ;
              tmrNext   = T_ACQ;
            end else begin
              chanNext  = chan + 1'b1;
              stateNext = S_GAP;
              tmrNext   = T_GAP;
            end
          end else begin
            bitNext   = bitCnt + 1'b1;
            stateNext = S_LOW;
            tmrNext   = T_HALF;
          end
        end
      end
      S_ACQ: begin
        if (tmrDone) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign chanIdx = chan;
  assign cnvOut  = (state == S_CONV) || (state == S_GAP) ||
                   (state == S_LOW)  || (state == S_HIGH);
  assign sckOut  = (state == S_HIGH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign selN[i] = !(((state == S_LOW) || (state == S_HIGH)) && (chan == CH_W'(i)));
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic              dataIn,
  input  logic [CH_W-1:0]   chanIdx,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [CH_W-1:0]   outChan
);

  logic [WORD_W-2:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.clrShift) begin
      shiftReg <= '0;
    end else if (ctl.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-3:0], dataIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
    end else if (ctl.loadOut) begin
      outValid <= 1'b1;
      outData  <= {shiftReg, dataIn};
      outChan  <= chanIdx;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SCK_HALF    = 2,
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 8,
  localparam int WORD_W     = 16,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              cnvOut,
  output logic              sckOut,
  output logic [NUM_CH-1:0] selN,
  input  logic              dataIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic [CH_W-1:0]   outChan
);

  dp_ctrl_t        ctl;
  logic [CH_W-1:0] chanIdx;

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .SCK_HALF(SCK_HALF), .CONV_CYCLES(CONV_CYCLES),
    .ACQ_CYCLES(ACQ_CYCLES), .WORD_W(WORD_W), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .outValid(outValid),
    .ctl(ctl), .chanIdx(chanIdx), .cnvOut(cnvOut), .sckOut(sckOut), .selN(selN)
  );

  adc_seq_dp #(
    .WORD_W(WORD_W), .CH_W(CH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn), .chanIdx(chanIdx),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outChan(outChan)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH      = 4,
  parameter int CONV_CYCLES = 20,
  parameter int WORD_W      = 16,
  parameter int CH_W        = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cnvOut,
  input logic              sckOut,
  input logic [NUM_CH-1:0] selN,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic [CH_W-1:0]   outChan
);

  localparam int CW = $clog2(CONV_CYCLES + 1) + 1;

  logic          cnvQ;
  logic [CW-1:0] convCnt;
  logic          cnvRise;

  assign cnvRise = cnvOut && !cnvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnvQ    <= 1'b0;
      convCnt <= '0;
    end else begin
      cnvQ <= cnvOut;
      if (cnvRise) convCnt <= CW'(1);
      else if (convCnt != '0 && convCnt < CW'(CONV_CYCLES)) convCnt <= convCnt + 1'b1;
      else convCnt <= '0;
    end
  end

  a_r4_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~selN) <= 1);

  a_r2_sel_high_at_cnv_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnvOut) |-> (&selN));

  a_r2_cnv_covers_read: assert property (@(posedge clk) disable iff (!rstN)
    (~selN != '0) |-> cnvOut);

  a_r3_conv_window: assert property (@(posedge clk) disable iff (!rstN)
    (cnvRise || (convCnt != '0 && convCnt < CW'(CONV_CYCLES))) |-> (&selN));

  a_r5_sck_low_at_sel_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selN) |-> !sckOut);

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outChan)));

  a_r8_no_read_while_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(~selN != '0) |-> !outValid);

  a_r10_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outChan) < NUM_CH));

endmodule

bind adc_seq_host adc_seq_chk #(
  .NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES), .WORD_W(WORD_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cnvOut(cnvOut), .sckOut(sckOut), .selN(selN),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outChan(outChan)
);

// File: tb/sim_adc_seq_host.sv
module sim_adc_seq_host;

  localparam int CLK_PERIOD  = 10;
  localparam int NUM_CH      = 4;
  localparam int SCK_HALF    = 2;
  localparam int CONV_CYCLES = 20;
  localparam int ACQ_CYCLES  = 8;
  localparam int CH_W        = 2;
  localparam int NROW        = 3;

  localparam logic [15:0] VEC [0:NROW-1][0:NUM_CH-1] = '{
    '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF},
    '{16'h0000, 16'h7FFE, 16'h1234, 16'hC001},
    '{16'h5A5A, 16'hDEAD, 16'h0F0F, 16'h8001}
  };
  localparam int STALL [0:NROW-1] = '{0, 3, 25};

  logic              clk = 1'b0;
  logic              rstN;
  logic              startReq;
  logic              cnvOut, sckOut;
  logic [NUM_CH-1:0] selN;
  logic              dataIn;
  logic              outValid, outReady;
  logic [15:0]       outData;
  logic [CH_W-1:0]   outChan;

  int checks = 0, errors = 0;
  int monChecks = 0, monErrors = 0;
  int cnvRises = 0, expRises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_host #(
    .NUM_CH(NUM_CH), .SCK_HALF(SCK_HALF), .CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cnvOut(cnvOut), .sckOut(sckOut),
    .selN(selN), .dataIn(dataIn), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outChan(outChan)
  );

  // Converter model: MSB on select fall, next bit after each clock fall
  logic [15:0]       words [NUM_CH];
  int                bitIdx = 15;
  int                actCh = -1;
  logic [NUM_CH-1:0] prevSelM = '1;

  always @(selN or negedge sckOut) begin
    if (selN !== prevSelM) begin
      prevSelM = selN;
      bitIdx   = 15;
      actCh    = -1;
      for (int i = 0; i < NUM_CH; i++) if (!selN[i]) actCh = i;
    end else if (!sckOut) begin
      bitIdx = bitIdx - 1;
    end
  end

  assign dataIn = (actCh >= 0 && bitIdx >= 0) ? words[actCh][bitIdx] : 1'b0;

  // Bus monitor, sampled away from the active edge
  logic [NUM_CH-1:0] pSel = '1;
  logic              pSck = 1'b0, pCnv = 1'b0;
  int sckRise = 0, gapCnt = 0, convWait = 0, nextCh = 0;
  bit inGap = 0, fromConv = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      pSel = '1; pSck = 1'b0; pCnv = 1'b0;
      sckRise = 0; gapCnt = 0; inGap = 0; fromConv = 0;
    end else begin
      if (cnvOut && !pCnv) begin
        cnvRises++; convWait = 0; fromConv = 1; nextCh = 0; inGap = 0;
      end
      if (sckOut && !pSck) sckRise++;
      if (pSel != '1 && selN == '1) begin
        monChecks++;
        if (sckRise != 16) begin
          monErrors++;
          $display("FAIL R5 clock pulses per select actual=%0d expected=16", sckRise);
        end
        sckRise = 0; gapCnt = 0; inGap = 1;
      end
      if (pSel == '1 && selN != '1) begin
        int ch = -1;
        for (int i = 0; i < NUM_CH; i++) if (!selN[i]) ch = i;
        monChecks++;
        if (ch != nextCh) begin
          monErrors++;
          $display("FAIL R4 select order actual=%0d expected=%0d", ch, nextCh);
        end
        nextCh = (nextCh + 1) % NUM_CH;
        if (inGap) begin
          monChecks++;
          if (gapCnt < 2*SCK_HALF) begin
            monErrors++;
            $display("FAIL R7 gap cycles actual=%0d expected>=%0d", gapCnt, 2*SCK_HALF);
          end
        end
        if (fromConv) begin
          monChecks++;
          if (convWait < CONV_CYCLES) begin
            monErrors++;
            $display("FAIL R3 conversion wait actual=%0d expected>=%0d", convWait, CONV_CYCLES);
          end
        end
        inGap = 0; fromConv = 0; sckRise = 0;
      end
      if (selN == '1) begin
        if (inGap) gapCnt++;
        if (fromConv && cnvOut) convWait++;
      end
      pSel = selN; pSck = sckOut; pCnv = cnvOut;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string what);
    check(cnvOut == 1'b0, "R1", {what, " cnv"}, int'(cnvOut), 0);
    check(sckOut == 1'b0, "R1", {what, " sck"}, int'(sckOut), 0);
    check(selN == '1, "R1", {what, " sel"}, int'(selN), (1 << NUM_CH) - 1);
    check(outValid == 1'b0, "R1", {what, " valid"}, int'(outValid), 0);
  endtask

  task automatic pulseStart;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic takeWord(input int ch, input int stall);
    int wd = 0;
    bit held = 1;
    logic [15:0] d0;
    while (!outValid && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    check(outValid == 1'b1, "R6", "word arrives", int'(outValid), 1);
    check(outData == words[ch], "R6", "word MSB first", int'(outData), int'(words[ch]));
    check(int'(outChan) == ch, "R10", "channel index", int'(outChan), ch);
    check(cnvOut == (ch < NUM_CH-1), "R9", "cnv vs last word", int'(cnvOut), int'(ch < NUM_CH-1));
    d0 = outData;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      if (!outValid || outData != d0 || int'(outChan) != ch || selN != '1) held = 0;
    end
    if (stall > 0) check(held, "R8", "hold while not ready", int'(held), 1);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid == 1'b0, "R8", "consumed on handshake", int'(outValid), 0);
  endtask

  task automatic runConv(input int stall, input bit extraStart);
    pulseStart();
    expRises++;
    check(cnvOut == 1'b1, "R2", "cnv one edge after start", int'(cnvOut), 1);
    check(selN == '1, "R2", "selects high at cnv rise", int'(selN), (1 << NUM_CH) - 1);
    if (extraStart) begin
      repeat (5) @(negedge clk);
      pulseStart();
    end
    for (int c = 0; c < NUM_CH; c++) takeWord(c, stall);
    repeat (ACQ_CYCLES + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks + monChecks + 1, errors + monErrors + 1);
    $finish;
  end

  initial begin
    bit quiet;
    rstN = 1'b0; startReq = 1'b0; outReady = 1'b0;
    for (int c = 0; c < NUM_CH; c++) words[c] = '0;
    repeat (3) @(negedge clk);
    checkIdle("in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("after reset");

    // vector table: patterns with different consumer stalls
    for (int r = 0; r < NROW; r++) begin
      for (int c = 0; c < NUM_CH; c++) words[c] = VEC[r][c];
      runConv(STALL[r], r == 1);
    end

    // R9: start during acquisition window ignored
    for (int c = 0; c < NUM_CH; c++) words[c] = 16'h3C3C ^ 16'(c * 16'h1111);
    pulseStart();
    expRises++;
    for (int c = 0; c < NUM_CH; c++) takeWord(c, 0);
    pulseStart();
    quiet = 1;
    repeat (CONV_CYCLES + ACQ_CYCLES + 20) begin
      @(negedge clk);
      if (cnvOut || selN != '1) quiet = 0;
    end
    check(quiet, "R9", "start in acquisition ignored", int'(quiet), 1);
    runConv(0, 0);

    // R1: reset in the middle of a read
    for (int c = 0; c < NUM_CH; c++) words[c] = 16'h9669;
    pulseStart();
    expRises++;
    while (selN == '1) @(negedge clk);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("mid-read reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("after mid-read reset");
    for (int c = 0; c < NUM_CH; c++) words[c] = 16'h00FF << c;
    runConv(1, 0);

    check(cnvRises == expRises, "R9", "conversion count", cnvRises, expRises);

    $display("  CHECKS %0d ERRORS %0d", checks + monChecks, errors + monErrors);
    $finish;
  end

endmodule